// File: doc/BRIEF.md
# Dual-Window Bank Address Mapper

This block turns host accesses that fall inside a 64 KB graphics aperture (host address range A0000h to AFFFFh by default) into linear video-memory addresses. Two programmable bank registers each hold a bank number in 4 KB units. A layout bit in a control register chooses how the aperture is carved up. With the bit clear, the whole 64 KB window is served by the low bank register. With the bit set, the aperture becomes two 32 KB windows: the lower half is served by the low bank register and the upper half by the high bank register.

Software programs the bank and control registers through a small indexed write/read port. Each host access arrives with a valid strobe. One clock later the block reports a result valid flag, an in-aperture hit flag and the translated memory address. The translated address is the selected bank times 4096 plus the access offset measured from the start of the window it landed in. A second control bit is stored and brought out as the enable for the extended write modes, which other logic consumes.

Widths, the aperture base, the bank granularity, the register indices and the control-bit positions are all parameters. An output-register option selects between a registered result and a purely combinational one.

Top module: `bank_window_mapper`

## Requirements
- R1: After a synchronous reset, both bank registers and the control register read 0, and `xlat_valid`, `hit`, `mem_addr` and `ext_wr_en` are 0 in the first cycle after reset is released.
- R2: With control bit 0 clear, a hit access at host address A in A0000h..AFFFFh yields `mem_addr` = low_bank*4096 + (A - A0000h), whatever the high bank holds.
- R3: With control bit 0 set, a hit access in A0000h..A7FFFh yields `mem_addr` = low_bank*4096 + (A - A0000h).
- R4: With control bit 0 set, a hit access in A8000h..AFFFFh yields `mem_addr` = high_bank*4096 + (A - A8000h).
- R5: A valid access whose upper host-address bits differ from the aperture base gives `hit` = 0 and `mem_addr` = 0.
- R6: Register index 0 holds the low bank and index 1 the high bank. Each stores 7 bits, takes write-data bits 6..0, and reads bit 7 as 0. Index 2 holds the 8-bit control register. A write to any other index changes nothing, and a read of any other index returns 0.
- R7: `xlat_valid` equals `host_valid` from one cycle earlier. `hit` is never 1 without `xlat_valid`. Exactly one result appears per valid access, in order.
- R8: An access presented in the same cycle as a register write is translated with the old register value. An access in the following cycle uses the new value.
- R9: `ext_wr_en` equals control bit 2, and it changes only after a write to index 2.
- R10: Bank number 127 combined with the largest offset (AFFFFh in the single-window layout) produces 8EFFFh without truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Register index for writes and reads |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_idx` (combinational) |
| host_valid | input | 1 | Host access strobe |
| host_addr | input | HOST_AW | Host byte address |
| xlat_valid | output | 1 | Result valid for the access of the previous cycle |
| hit | output | 1 | Access fell inside the aperture |
| mem_addr | output | MEM_AW | Translated video-memory address, 0 on a miss |
| ext_wr_en | output | 1 | Extended write-mode enable (control bit 2) |

## Verification
The bench builds the mapper with its default parameters: a 20-bit host address, 7-bit banks of 4 KB, a 64 KB aperture at A0000h, a 3-bit register index and a registered result. With these values, bank 127 plus a full 64 KB offset drives the carry into the top bit of the 20-bit memory address. Unused indices 3 to 7 exist, so writes and reads to unmapped registers can be tried. The one-cycle result delay lets a register write and an access share a single cycle, which puts the old-value/new-value ordering within reach.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

   // Which of the two bank registers serves an access
   typedef enum logic {
      WIN_LOW  = 1'b0,
      WIN_HIGH = 1'b1
   } win_sel_e;

   localparam int NUM_WINDOWS = 2;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Memory address width: bank base or window offset, whichever is wider, plus carry
   function automatic int mem_width(input int bank_w, input int gran_lg2, input int win_lg2);
      return max_int(bank_w + gran_lg2, win_lg2) + 1;
   endfunction

endpackage

// File: rtl/bankmap_regs.sv
module bankmap_regs
   import bankmap_pkg::*;
#(
   parameter int BANK_W = 7,
   parameter int DATA_W = 8,
   parameter int IDX_W = 3,
   parameter int IDX_BANK_BASE = 0,
   parameter int IDX_CTRL = 2,
   parameter int SPLIT_BIT = 0,
   parameter int XWR_BIT = 2
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               idx,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [DATA_W-1:0]              rd_data,
   output logic [NUM_WINDOWS*BANK_W-1:0]  banks,
   output logic                           split,
   output logic                           xwr
);

   logic [DATA_W-1:0] ctrl_q;
   logic [BANK_W-1:0] bank_v [NUM_WINDOWS];

   // One bank register per window, at consecutive indices
   for (genvar b = 0; b < NUM_WINDOWS; b++) begin : g_bank
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX_BANK_BASE + b);
      logic [BANK_W-1:0] q;

      always_ff @(posedge clk) begin
         if (rst) begin
            q <= '0;
         end else if (wr_en && (idx == MY_IDX)) begin
            q <= wr_data[BANK_W-1:0];
         end
      end

      assign bank_v[b] = q;
      assign banks[b*BANK_W +: BANK_W] = q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
      end else if (wr_en && (idx == IDX_W'(IDX_CTRL))) begin
         ctrl_q <= wr_data;
      end
   end

   // Read mux: unmapped indices return zero
   always_comb begin
      rd_data = '0;
      if (idx == IDX_W'(IDX_CTRL)) begin
         rd_data = ctrl_q;
      end
      for (int b = 0; b < NUM_WINDOWS; b++) begin
         if (idx == IDX_W'(IDX_BANK_BASE + b)) begin
            rd_data = DATA_W'(bank_v[b]);
         end
      end
   end

   assign split = ctrl_q[SPLIT_BIT];
   assign xwr   = ctrl_q[XWR_BIT];

endmodule

// File: rtl/bankmap_decode.sv
module bankmap_decode
   import bankmap_pkg::*;
#(
   parameter int HOST_AW = 20,
   parameter int WIN_LG2 = 16,
   parameter logic [HOST_AW-1:0] APER_BASE = 20'hA0000
) (
   input  logic [HOST_AW-1:0] addr,
   input  logic               split,
   output logic               in_aper,
   output win_sel_e           win,
   output logic [WIN_LG2-1:0] offset
);

   localparam int TAG_W = HOST_AW - WIN_LG2;
   localparam logic [TAG_W-1:0] APER_TAG = APER_BASE[HOST_AW-1:WIN_LG2];

   logic top_half;

   assign in_aper  = (addr[HOST_AW-1:WIN_LG2] == APER_TAG);
   assign top_half = addr[WIN_LG2-1];

   always_comb begin
      if (split) begin
         // Two half-size windows: the top offset bit picks the window and is dropped
         win    = top_half ? WIN_HIGH : WIN_LOW;
         offset = {1'b0, addr[WIN_LG2-2:0]};
      end else begin
         win    = WIN_LOW;
         offset = addr[WIN_LG2-1:0];
      end
   end

endmodule

// File: rtl/bankmap_compose.sv
module bankmap_compose #(
   parameter int BANK_W = 7,
   parameter int GRAN_LG2 = 12,
   parameter int WIN_LG2 = 16,
   parameter int MEM_AW = 20
) (
   input  logic [BANK_W-1:0]  bank,
   input  logic [WIN_LG2-1:0] offset,
   output logic [MEM_AW-1:0]  addr
);

   logic [MEM_AW-1:0] base;

   assign base = MEM_AW'(bank) << GRAN_LG2;
   assign addr = base + MEM_AW'(offset);

endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
   import bankmap_pkg::*;
#(
   parameter int HOST_AW = 20,
   parameter int BANK_W = 7,
   parameter int GRAN_LG2 = 12,
   parameter int WIN_LG2 = 16,
   parameter logic [HOST_AW-1:0] APER_BASE = 20'hA0000,
   parameter int DATA_W = 8,
   parameter int IDX_W = 3,
   parameter int IDX_BANK_BASE = 0,
   parameter int IDX_CTRL = 2,
   parameter int SPLIT_BIT = 0,
   parameter int XWR_BIT = 2,
   parameter bit OUT_REG = 1'b1,
   localparam int MEM_AW = mem_width(BANK_W, GRAN_LG2, WIN_LG2)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               reg_we,
   input  logic [IDX_W-1:0]   reg_idx,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               host_valid,
   input  logic [HOST_AW-1:0] host_addr,
   output logic               xlat_valid,
   output logic               hit,
   output logic [MEM_AW-1:0]  mem_addr,
   output logic               ext_wr_en
);

   // Elaboration-time parameter checks
   if (BANK_W < 1 || BANK_W > DATA_W) begin : g_chk_bank
      $error("bank_window_mapper: BANK_W must be 1..DATA_W");
   end
   if (WIN_LG2 < 2 || HOST_AW <= WIN_LG2) begin : g_chk_win
      $error("bank_window_mapper: need 2 <= WIN_LG2 < HOST_AW");
   end
   if (APER_BASE[WIN_LG2-1:0] != '0) begin : g_chk_base
      $error("bank_window_mapper: APER_BASE must be aligned to the aperture");
   end
   if (SPLIT_BIT >= DATA_W || XWR_BIT >= DATA_W || SPLIT_BIT == XWR_BIT) begin : g_chk_bits
      $error("bank_window_mapper: control bit positions invalid");
   end
   if (IDX_CTRL >= (1 << IDX_W) || IDX_BANK_BASE + NUM_WINDOWS > (1 << IDX_W) ||
       (IDX_CTRL >= IDX_BANK_BASE && IDX_CTRL < IDX_BANK_BASE + NUM_WINDOWS)) begin : g_chk_idx
      $error("bank_window_mapper: register indices overlap or do not fit");
   end

   logic [NUM_WINDOWS*BANK_W-1:0] banks;
   logic                          split;
   logic                          in_aper;
   win_sel_e                      win;
   logic [WIN_LG2-1:0]            offset;
   logic [BANK_W-1:0]             bank_sel;
   logic [MEM_AW-1:0]             addr_c;
   logic                          hit_c;
   logic [MEM_AW-1:0]             addr_n;

   bankmap_regs #(
      .BANK_W(BANK_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
      .IDX_BANK_BASE(IDX_BANK_BASE), .IDX_CTRL(IDX_CTRL),
      .SPLIT_BIT(SPLIT_BIT), .XWR_BIT(XWR_BIT)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_en(reg_we), .idx(reg_idx),
      .wr_data(reg_wdata), .rd_data(reg_rdata),
      .banks(banks), .split(split), .xwr(ext_wr_en)
   );

   bankmap_decode #(
      .HOST_AW(HOST_AW), .WIN_LG2(WIN_LG2), .APER_BASE(APER_BASE)
   ) u_decode (
      .addr(host_addr), .split(split), .in_aper(in_aper),
      .win(win), .offset(offset)
   );

   assign bank_sel = (win == WIN_HIGH) ? banks[BANK_W +: BANK_W] : banks[0 +: BANK_W];

   bankmap_compose #(
      .BANK_W(BANK_W), .GRAN_LG2(GRAN_LG2), .WIN_LG2(WIN_LG2), .MEM_AW(MEM_AW)
   ) u_compose (
      .bank(bank_sel), .offset(offset), .addr(addr_c)
   );

   assign hit_c  = host_valid && in_aper;
   assign addr_n = hit_c ? addr_c : '0;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            xlat_valid <= 1'b0;
            hit        <= 1'b0;
            mem_addr   <= '0;
         end else begin
            xlat_valid <= host_valid;
            hit        <= hit_c;
            mem_addr   <= addr_n;
         end
      end
   end else begin : g_out_comb
      assign xlat_valid = host_valid;
      assign hit        = hit_c;
      assign mem_addr   = addr_n;
   end

endmodule

// File: rtl/bank_window_mapper_chk.sv
module bank_window_mapper_chk #(
   parameter int TAG_W = 4,
   parameter logic [TAG_W-1:0] APER_TAG = 4'hA,
   parameter int GRAN_LG2 = 12,
   parameter int MEM_AW = 20,
   parameter int DATA_W = 8,
   parameter int IDX_W = 3,
   parameter int IDX_BANK_BASE = 0,
   parameter int IDX_CTRL = 2,
   parameter bit OUT_REG = 1'b1
) (
   input logic                clk,
   input logic                rst,
   input logic                reg_we,
   input logic [IDX_W-1:0]    reg_idx,
   input logic [DATA_W-1:0]   reg_rdata,
   input logic                host_valid,
   input logic [TAG_W-1:0]    host_tag,
   input logic [GRAN_LG2-1:0] host_low,
   input logic                xlat_valid,
   input logic                hit,
   input logic [MEM_AW-1:0]   mem_addr,
   input logic                ext_wr_en
);

   logic unmapped;
   assign unmapped = (reg_idx != IDX_W'(IDX_CTRL)) &&
                     (reg_idx != IDX_W'(IDX_BANK_BASE)) &&
                     (reg_idx != IDX_W'(IDX_BANK_BASE + 1));

   assert_unmapped_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
      unmapped |-> (reg_rdata == '0));

   assert_hit_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
      hit |-> xlat_valid);

   assert_miss_addr_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (xlat_valid && !hit) |-> (mem_addr == '0));

   assert_xwr_only_on_write_R9: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && !($past(reg_we) && ($past(reg_idx) == IDX_W'(IDX_CTRL)))) |-> $stable(ext_wr_en));

   if (OUT_REG) begin : g_timed
      assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
         $past(rst) |-> (!xlat_valid && !hit && !ext_wr_en && (mem_addr == '0)));

      assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
         $past(!rst) |-> (xlat_valid == $past(host_valid)));

      assert_hit_in_aperture_R5: assert property (@(posedge clk) disable iff (rst)
         ($past(!rst) && hit) |-> ($past(host_tag) == APER_TAG));

      assert_low_bits_pass_R2: assert property (@(posedge clk) disable iff (rst)
         ($past(!rst) && hit) |-> (mem_addr[GRAN_LG2-1:0] == $past(host_low)));
   end

endmodule

bind bank_window_mapper bank_window_mapper_chk #(
   .TAG_W(HOST_AW - WIN_LG2),
   .APER_TAG(APER_BASE[HOST_AW-1:WIN_LG2]),
   .GRAN_LG2(GRAN_LG2),
   .MEM_AW(MEM_AW),
   .DATA_W(DATA_W),
   .IDX_W(IDX_W),
   .IDX_BANK_BASE(IDX_BANK_BASE),
   .IDX_CTRL(IDX_CTRL),
   .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
   .reg_rdata(reg_rdata), .host_valid(host_valid),
   .host_tag(host_addr[HOST_AW-1:WIN_LG2]), .host_low(host_addr[GRAN_LG2-1:0]),
   .xlat_valid(xlat_valid), .hit(hit), .mem_addr(mem_addr), .ext_wr_en(ext_wr_en)
);

// File: tb/tb_bank_window_mapper.sv
`timescale 1ns/1ps
module tb_bank_window_mapper;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_idx = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        host_valid = 1'b0;
   logic [19:0] host_addr = '0;
   logic        xlat_valid;
   logic        hit;
   logic [19:0] mem_addr;
   logic        ext_wr_en;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // bench model of the registers
   logic [6:0] m_lo = '0;
   logic [6:0] m_hi = '0;
   logic [7:0] m_ctrl = '0;

   // scoreboard items: {hit, addr}, plus requirement tag
   logic [20:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   bank_window_mapper dut (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .host_valid(host_valid), .host_addr(host_addr),
      .xlat_valid(xlat_valid), .hit(hit), .mem_addr(mem_addr),
      .ext_wr_en(ext_wr_en)
   );

   function automatic logic [20:0] model(input logic [19:0] a);
      logic [19:0] r;
      if (a[19:16] != 4'hA) return 21'd0;
      if (m_ctrl[0]) begin
         if (a[15]) r = 20'({m_hi, 12'h000}) + 20'(a[14:0]);
         else       r = 20'({m_lo, 12'h000}) + 20'(a[14:0]);
      end else begin
         r = 20'({m_lo, 12'h000}) + 20'(a[15:0]);
      end
      return {1'b1, r};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One cycle of stimulus: optional register write, optional access
   task automatic cyc(input bit we, input logic [2:0] idx, input logic [7:0] d,
                      input bit av, input logic [19:0] a, input string req);
      @(negedge clk);
      reg_we = we; reg_idx = idx; reg_wdata = d;
      host_valid = av; host_addr = a;
      if (av) begin
         exp_q.push_back(model(a));
         tag_q.push_back(req);
      end
      if (we) begin
         case (idx)
            3'd0: m_lo = d[6:0];
            3'd1: m_hi = d[6:0];
            3'd2: m_ctrl = d;
            default: ;
         endcase
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [7:0] d);
      cyc(1'b1, idx, d, 1'b0, 20'h0, "");
   endtask

   task automatic acc(input logic [19:0] a, input string req);
      cyc(1'b0, 3'd0, 8'h00, 1'b1, a, req);
   endtask

   task automatic rd_check(input logic [2:0] idx, input logic [7:0] exp, input string req);
      @(negedge clk);
      reg_we = 1'b0; host_valid = 1'b0; reg_idx = idx;
      #1 check(req, 32'(reg_rdata), 32'(exp));
   endtask

   // Monitor: pop and compare each produced result
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (!rst && xlat_valid) begin
            if (exp_q.size() == 0) begin
               check("R7 spurious result", 32'(xlat_valid), 32'd0);
            end else begin
               logic [20:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({t, " hit"}, 32'(hit), 32'(e[20]));
               check({t, " addr"}, 32'(mem_addr), 32'(e[19:0]));
            end
         end else if (!rst && hit) begin
            check("R7 hit without valid", 32'(hit), 32'd0);
         end
      end
   end

   // Watchdog
   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      #1 check("R1 xlat_valid", 32'(xlat_valid), 32'd0);
      check("R1 hit", 32'(hit), 32'd0);
      check("R1 mem_addr", 32'(mem_addr), 32'd0);
      check("R1 ext_wr_en", 32'(ext_wr_en), 32'd0);
      rd_check(3'd0, 8'h00, "R1 low bank");
      rd_check(3'd1, 8'h00, "R1 high bank");
      rd_check(3'd2, 8'h00, "R1 control");

      // R2: single window, high bank ignored
      wr(3'd0, 8'h05);
      wr(3'd1, 8'h33);
      rd_check(3'd0, 8'h05, "R6 low readback");
      rd_check(3'd1, 8'h33, "R6 high readback");
      acc(20'hA0000, "R2 base");
      acc(20'hAFFFF, "R2 top");
      acc(20'hA8010, "R2 upper half uses low");
      acc(20'hA1234, "R2 mid");

      // R5: outside the aperture
      acc(20'h9FFFF, "R5 below");
      acc(20'hB0000, "R5 above");
      acc(20'h00000, "R5 zero");
      cyc(1'b0, 3'd0, 8'h00, 1'b0, 20'hA0000, "");
      cyc(1'b0, 3'd0, 8'h00, 1'b0, 20'hA0000, "");

      // R3 / R4: split layout
      wr(3'd2, 8'h01);
      acc(20'hA0000, "R3 low start");
      acc(20'hA7FFF, "R3 low end");
      acc(20'hA8000, "R4 high start");
      acc(20'hAFFFF, "R4 high end");
      acc(20'hAC123, "R4 high mid");
      acc(20'h7C123, "R5 split miss");

      // R10: widest result, single layout; R6 bit 7 dropped
      wr(3'd2, 8'h00);
      wr(3'd0, 8'hFF);
      rd_check(3'd0, 8'h7F, "R6 bit7 dropped");
      acc(20'hAFFFF, "R10 max address");
      wr(3'd2, 8'h01);
      wr(3'd1, 8'h7F);
      acc(20'hAFFFF, "R10 split max");

      // R8: write and access in the same cycle
      wr(3'd2, 8'h00);
      wr(3'd0, 8'h05);
      cyc(1'b1, 3'd0, 8'h09, 1'b1, 20'hA0100, "R8 old value");
      acc(20'hA0100, "R8 new value");
      cyc(1'b1, 3'd2, 8'h01, 1'b1, 20'hA9000, "R8 old layout");
      acc(20'hA9000, "R8 new layout");

      // R9: extended write enable follows control bit 2
      wr(3'd2, 8'h04);
      @(negedge clk); #1 check("R9 ext_wr_en set", 32'(ext_wr_en), 32'd1);
      acc(20'hA9000, "R9 bit2 alone keeps single layout");
      wr(3'd2, 8'h05);
      @(negedge clk); #1 check("R9 ext_wr_en kept", 32'(ext_wr_en), 32'd1);
      wr(3'd2, 8'h01);
      @(negedge clk); #1 check("R9 ext_wr_en clear", 32'(ext_wr_en), 32'd0);

      // R6: unmapped indices
      wr(3'd3, 8'hAA);
      wr(3'd7, 8'h55);
      rd_check(3'd3, 8'h00, "R6 unmapped read 3");
      rd_check(3'd7, 8'h00, "R6 unmapped read 7");
      rd_check(3'd0, 8'h09, "R6 low unchanged");
      rd_check(3'd1, 8'h7F, "R6 high unchanged");
      rd_check(3'd2, 8'h01, "R6 control unchanged");

      // R7: back-to-back and gapped accesses
      acc(20'hA0001, "R7 burst a");
      acc(20'hA8002, "R7 burst b");
      cyc(1'b0, 3'd0, 8'h00, 1'b0, 20'hA0000, "");
      acc(20'h12345, "R7 after gap");
      cyc(1'b0, 3'd0, 8'h00, 1'b0, 20'h0, "");
      repeat (3) @(negedge clk);
      #5 check("R7 all results seen", 32'(exp_q.size()), 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule